// File: doc/BRIEF.md
# Frame rate calibration controller

This block derives the frame-period divisor for a display timing generator from a calibration window whose length the host sets. The host raises a calibrate bit to open the window and lowers it to close the window. While the window is open, the block counts clock cycles of the local oscillator, which is the block clock. It also counts a 1 ms reference tick to measure the window's length in milliseconds.

When the window closes, the length is judged. A length inside the acceptance band replaces the divisor with the cycle count divided by 16. Dividing by 16 is correct because a nominal 200 ms window spans sixteen frames at 80 Hz. Any other length leaves the last accepted divisor in place. In every case a one-cycle report pulse says whether the attempt was taken.

Every close starts a 500 ms lockout. No new window can open during the lockout. No window opens while power-down is asserted, and asserting power-down during a window closes it as rejected.

The controller has three states:
- IDLE → OPEN: taken on a start edge without power-down.
- OPEN → LOCK: taken on a stop edge or on power-down.
- LOCK → IDLE: taken once the lockout count is full.

Top module: `frame_cal_ctrl`

## Requirements
- R1: After reset, `frame_div` holds 100, and `cal_busy`, `cal_done` and `cal_ok` are 0.
- R2: A rising edge of `cal_req`, sampled in IDLE with `pwr_down` low, raises `cal_busy` from the next cycle. `cal_busy` stays high until the window closes.
- R3: A rising edge of `cal_req` sampled while `pwr_down` is high opens no window, and `frame_div` is untouched.
- R4: A window whose tick count is between 190 and 210 inclusive is accepted. One cycle after the stop edge, `cal_done` and `cal_ok` are both 1 for exactly one cycle, and `frame_div` becomes the window's cycle count shifted right by 4.
- R5: A window of any other length is rejected, including the 58–189 and 211–690 ranges. `cal_done` pulses with `cal_ok` at 0 and `frame_div` keeps its value.
- R6: The millisecond count saturates at 691. A window held open beyond 690 ms keeps `cal_busy` high and is rejected when it closes.
- R7: After each close, 500 ticks must be counted before the block returns to IDLE. A rising edge sampled before the return is ignored. After the return, a fresh rising edge is needed.
- R8: `pwr_down` high in OPEN closes the window as rejected and starts the lockout. This also holds when it coincides with the stop edge.
- R9: Cycles and ticks are counted only on the clock edges strictly between the edge that samples the start and the edge that samples the stop. A tick arriving on the stop edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock; all cycle counting uses it |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Power-down state of the display driver |
| cal_req | input | 1 | Calibrate bit; 1 opens a window, 0 closes it |
| ms_tick | input | 1 | One-cycle pulse every millisecond, synchronous to `clk` |
| frame_div | output | DIV_W (16) | Last accepted frame-period divisor |
| cal_busy | output | 1 | Window open |
| cal_done | output | 1 | One-cycle pulse after a window closes |
| cal_ok | output | 1 | With `cal_done`: 1 if the divisor was updated |

## Verification
Several events can land on the same clock edge, and the bench provokes each collision directly:
- **Tick on the stop edge.** The bench holds the close of one window until the tick generator will pulse on the very edge that samples the stop. The expected divisor is then built without that tick.
- **Power-down with stop.** Power-down is raised together with the falling calibrate bit. The expected outcome is a rejected report.
- **Lockout expiry with a new start.** Start requests are placed just before and just after the earliest edge at which the lockout can have expired.

A behavioural model advances on every clock and judges every output on every cycle, so the cycle on which each collision resolves is checked, not just the end result.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_LOCK = 2'd2
    } fcc_state_e;

endpackage

// File: rtl/fcc_tick_counter.sv
// Counts qualified ticks and holds at LIMIT; used for window length and lockout.
module fcc_tick_counter #(
    parameter int LIMIT = 500,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         tick,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && tick && (count != LIM)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fcc_cycle_counter.sv
// Counts oscillator cycles while enabled; exposes the count divided by 2**SHIFT.
module fcc_cycle_counter #(
    parameter int CNT_W = 20,
    parameter int SHIFT = 4,
    localparam int Q_W = CNT_W - SHIFT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    output logic [Q_W-1:0] quotient
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en && (cnt != {CNT_W{1'b1}})) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign quotient = cnt[CNT_W-1:SHIFT];
endmodule

// File: rtl/frame_cal_ctrl.sv
module frame_cal_ctrl
    import fcc_pkg::*;
#(
    parameter int DIV_W         = 16,
    parameter int DIV_SHIFT     = 4,
    parameter int ACCEPT_MIN_MS = 190,
    parameter int ACCEPT_MAX_MS = 210,
    parameter int LOCKOUT_MS    = 500,
    parameter int WIN_SAT_MS    = 691,
    parameter int RESET_DIV     = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             cal_req,
    input  logic             ms_tick,
    output logic [DIV_W-1:0] frame_div,
    output logic             cal_busy,
    output logic             cal_done,
    output logic             cal_ok
);
    localparam int OSC_W  = DIV_W + DIV_SHIFT;
    localparam int WIN_W  = $clog2(WIN_SAT_MS + 1);
    localparam int LOCK_W = $clog2(LOCKOUT_MS + 1);
    localparam logic [WIN_W-1:0]  MIN_L  = WIN_W'(ACCEPT_MIN_MS);
    localparam logic [WIN_W-1:0]  MAX_L  = WIN_W'(ACCEPT_MAX_MS);
    localparam logic [WIN_W-1:0]  SAT_L  = WIN_W'(WIN_SAT_MS);
    localparam logic [LOCK_W-1:0] LOCK_L = LOCK_W'(LOCKOUT_MS);

    fcc_state_e state, state_nx;
    logic req_q;
    logic start_evt, stop_evt, open_go, close_evt, accept;
    logic [WIN_W-1:0]  win_cnt;
    logic [LOCK_W-1:0] lock_cnt;
    logic [DIV_W-1:0]  new_div;
    logic win_full, lock_full, in_band;

    // Edge detection on the calibrate bit
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= cal_req;
    end
    assign start_evt = cal_req & ~req_q;
    assign stop_evt  = ~cal_req & req_q;

    assign open_go   = (state == ST_IDLE) && start_evt && !pwr_down;
    assign close_evt = (state == ST_OPEN) && (stop_evt || pwr_down);
    assign in_band   = (win_cnt >= MIN_L) && (win_cnt <= MAX_L);
    assign accept    = close_evt && stop_evt && !pwr_down && in_band;
    assign win_full  = (win_cnt == SAT_L);
    assign lock_full = (lock_cnt == LOCK_L);

    fcc_tick_counter #(.LIMIT(WIN_SAT_MS)) win_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(open_go),
        .en(state == ST_OPEN), .tick(ms_tick), .count(win_cnt)
    );

    fcc_tick_counter #(.LIMIT(LOCKOUT_MS)) lock_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(close_evt),
        .en(state == ST_LOCK), .tick(ms_tick), .count(lock_cnt)
    );

    fcc_cycle_counter #(.CNT_W(OSC_W), .SHIFT(DIV_SHIFT)) osc_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(open_go),
        .en(state == ST_OPEN), .quotient(new_div)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (open_go)   state_nx = ST_OPEN;
            ST_OPEN: if (close_evt) state_nx = ST_LOCK;
            ST_LOCK: if (lock_full) state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_div <= DIV_W'(RESET_DIV);
            cal_done  <= 1'b0;
            cal_ok    <= 1'b0;
        end else begin
            cal_done <= close_evt;
            cal_ok   <= accept;
            if (accept) frame_div <= new_div;
        end
    end

    assign cal_busy = (state == ST_OPEN);

    // Divisor moves only on an accepted report
    assert_div_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_div != $past(frame_div)) |-> (cal_done && cal_ok));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    assert_ok_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cal_ok |-> cal_done);

    assert_open_not_in_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_busy) |-> !$past(pwr_down));

    assert_close_reports_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> cal_done);

    assert_lock_after_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |=> !cal_busy);

    assert_saturated_rejects_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_busy && win_full) |=> !cal_ok);

endmodule

// File: tb/frame_cal_ctrl_tb_top.sv
module frame_cal_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_EVERY = 4;
    localparam int RST_DIV    = 100;
    localparam int LOCK_MS    = 500;
    localparam int SAT_MS     = 691;

    logic clk = 1'b0, rst_n = 1'b0, pwr_down = 1'b0, cal_req = 1'b0, ms_tick = 1'b0;
    logic [15:0] frame_div;
    logic cal_busy, cal_done, cal_ok;

    int vectors = 0, miscompares = 0;
    string cur_req = "R1";
    bit finished = 1'b0;
    int tick_ph = 0;
    int cur_div = RST_DIV;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_cal_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .cal_req(cal_req),
        .ms_tick(ms_tick), .frame_div(frame_div), .cal_busy(cal_busy),
        .cal_done(cal_done), .cal_ok(cal_ok)
    );

    // Free-running 1 ms reference: one pulse every TICK_EVERY cycles
    always @(negedge clk) begin
        tick_ph <= (tick_ph + 1) % TICK_EVERY;
        ms_tick <= (tick_ph == TICK_EVERY - 1);
    end

    // Behavioural reference model
    int m_st = 0, m_reqq = 0, m_ms = 0, m_osc = 0, m_lock = 0, m_div = RST_DIV;
    bit m_done = 0, m_ok = 0;
    always @(posedge clk) begin
        bit s_e, p_e, cl, ac;
        if (!rst_n) begin
            m_st = 0; m_reqq = 0; m_ms = 0; m_osc = 0; m_lock = 0;
            m_div = RST_DIV; m_done = 0; m_ok = 0;
        end else begin
            s_e = cal_req && (m_reqq == 0);
            p_e = !cal_req && (m_reqq == 1);
            cl = 0; ac = 0;
            if (m_st == 0) begin
                if (s_e && !pwr_down) begin m_st = 1; m_ms = 0; m_osc = 0; end
            end else if (m_st == 1) begin
                if (p_e || pwr_down) begin
                    cl = 1;
                    ac = p_e && !pwr_down && m_ms >= 190 && m_ms <= 210;
                    if (ac) m_div = (m_osc >> 4) & 16'hFFFF;
                    m_st = 2; m_lock = 0;
                end else begin
                    if (m_osc < (1 << 20) - 1) m_osc++;
                    if (ms_tick && m_ms < SAT_MS) m_ms++;
                end
            end else begin
                if (m_lock == LOCK_MS) m_st = 0;
                else if (ms_tick) m_lock++;
            end
            m_done = cl; m_ok = ac; m_reqq = cal_req ? 1 : 0;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            vectors++;
            if (int'(frame_div) !== m_div || cal_busy !== (m_st == 1) ||
                cal_done !== m_done || cal_ok !== m_ok) begin
                miscompares++;
                $display("FAIL %s model: div=%0d busy=%0b done=%0b ok=%0b exp div=%0d busy=%0b done=%0b ok=%0b",
                         cur_req, frame_div, cal_busy, cal_done, cal_ok,
                         m_div, (m_st == 1), m_done, m_ok);
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Opens a window, holds it c cycles (optionally until the stop edge carries a tick),
    // then checks the report against the band rule applied to the bench's own tally.
    task automatic run_window(input string req, input int c, input bit align, input bit pd_at_stop);
        int ms = 0, osc = 0;
        bit acc;
        cur_req = req;
        step(1);
        cal_req = 1'b1;
        for (int k = 1; k < c; k++) begin
            step(1);
            if (k == 1) check("R2", "busy after start", int'(cal_busy), 1);
            if (ms_tick) ms++;
            osc++;
        end
        step(1);
        if (align) begin
            while (!ms_tick) begin osc++; step(1); end
        end
        if (ms > 690) check("R6", "busy in overlong window", int'(cal_busy), 1);
        cal_req = 1'b0;
        if (pd_at_stop) pwr_down = 1'b1;
        acc = !pd_at_stop && ms >= 190 && ms <= 210;
        if (acc) cur_div = (osc >> 4) & 16'hFFFF;
        step(1);
        check(req, "done after stop", int'(cal_done), 1);
        check(req, "ok after stop", int'(cal_ok), acc ? 1 : 0);
        check(req, "divisor", int'(frame_div), cur_div);
        pwr_down = 1'b0;
        step(1);
        check("R4", "done is one pulse", int'(cal_done), 0);
        check(req, "busy after close", int'(cal_busy), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        step(3);
        check("R1", "div in reset", int'(frame_div), RST_DIV);
        check("R1", "busy in reset", int'(cal_busy), 0);
        rst_n = 1'b1;
        step(1);
        check("R1", "div after reset", int'(frame_div), RST_DIV);
        check("R1", "done after reset", int'(cal_done), 0);
        check("R1", "ok after reset", int'(cal_ok), 0);

        // Accept band, including both edges
        run_window("R4", 801, 0, 0); check("R4", "200 ms divisor", int'(frame_div), 50); step(2100);
        run_window("R4", 761, 0, 0); check("R4", "190 ms divisor", int'(frame_div), 47); step(2100);
        run_window("R4", 841, 0, 0); check("R4", "210 ms divisor", int'(frame_div), 52); step(2100);
        // Rejections
        run_window("R5", 757, 0, 0); step(2100);
        run_window("R5", 845, 0, 0); step(2100);
        run_window("R5", 201, 0, 0); step(2100);
        run_window("R5", 401, 0, 0); step(2100);
        run_window("R5", 1601, 0, 0); check("R5", "divisor kept", int'(frame_div), 52); step(2100);
        run_window("R6", 2801, 0, 0); check("R6", "divisor kept", int'(frame_div), 52); step(2100);
        // Tick on the stop edge
        run_window("R9", 801, 1, 0); step(2100);
        // Power-down coinciding with stop
        run_window("R8", 801, 0, 1); step(2100);

        // Start during power-down
        cur_req = "R3";
        pwr_down = 1'b1; cal_req = 1'b1;
        step(5);
        check("R3", "no window in power-down", int'(cal_busy), 0);
        check("R3", "divisor untouched", int'(frame_div), cur_div);
        cal_req = 1'b0; step(1); pwr_down = 1'b0;
        step(3);
        check("R3", "still idle", int'(cal_busy), 0);

        // Lockout boundary
        run_window("R7", 801, 0, 0);
        cur_req = "R7";
        step(1994);
        cal_req = 1'b1;
        step(1); check("R7", "start in lockout ignored", int'(cal_busy), 0);
        step(1); check("R7", "start in lockout ignored", int'(cal_busy), 0);
        step(1); check("R7", "start in lockout ignored", int'(cal_busy), 0);
        cal_req = 1'b0;
        step(5);
        cal_req = 1'b1;
        step(1); check("R7", "start after lockout", int'(cal_busy), 1);
        step(20);
        cal_req = 1'b0;
        step(1); check("R7", "short window rejected", int'(cal_ok), 0);
        step(2100);

        // Power-down in the middle of a window
        cur_req = "R8";
        cal_req = 1'b1;
        step(300);
        pwr_down = 1'b1;
        step(1);
        check("R8", "done on power-down", int'(cal_done), 1);
        check("R8", "ok on power-down", int'(cal_ok), 0);
        check("R8", "busy on power-down", int'(cal_busy), 0);
        check("R8", "divisor kept", int'(frame_div), cur_div);
        pwr_down = 1'b0;
        step(10);
        cal_req = 1'b0;
        step(4);
        check("R8", "no reopen in lockout", int'(cal_busy), 0);
        step(50);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule